// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block sits on the card side of a two-wire serial bus and behaves like a small serial EEPROM. It samples the clock line and the data line, passes both through synchronisers into a faster system clock domain, and finds bus conditions and clock edges on the synchronised samples. It answers the device address 101000x and holds 512 bytes in an internal register array. It drives the data line only through a pull-low enable, so the line is never driven high.

Two operations are supported. A byte write is device address (write), word address, data and then stop. The data byte is acknowledged, but it is stored only when the stop arrives. After that a busy interval of a set number of system clocks follows, and during it the device address is not acknowledged. A random read starts with a write-mode transfer that loads the address pointer. A repeated start and the device address with the read bit follow, and the target then shifts out the byte at the pointer.

Top module: `i2c_ee_target`

## Requirements
- R1: After reset the pull-low enable is 0 and every memory byte reads as 0x00.
- R2: A start (SDA falling while SCL is high) begins a transfer. A first byte whose upper six bits are 101000 is acknowledged by pulling SDA low during the ninth SCL clock. Bit 0 of that byte is the direction: 1 is read, 0 is write.
- R3: A first byte with any other upper six bits gets no acknowledge. The target then ignores the bus until the next start, so later bytes are neither acknowledged nor stored.
- R4: In a write-mode transfer the second byte is acknowledged and loads bits 7:0 of the address pointer.
- R5: In a write the third byte is acknowledged, but memory is written only when a stop (SDA rising while SCL is high) follows. A repeated start in place of that stop discards the byte.
- R6: In a read-mode transfer the target sends the byte at the pointer, most significant bit first. Each bit stays stable while SCL is high. The master's acknowledge bit after the byte has no effect.
- R7: Bit 1 of the device byte becomes pointer bit 8, so device addresses 1010000 and 1010001 reach two separate 256-byte halves.
- R8: For BUSY_CYCLES system clocks after a write is committed, the device address is not acknowledged. After that interval it is acknowledged again.
- R9: The target only pulls SDA low, and the pull-low enable changes only while SCL is low.
- R10: In a write, any byte after the data byte is not acknowledged and is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock level, asynchronous |
| sda_i | input | 1 | Bus data level as seen on the wire, asynchronous |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it to the pull-up |

## Verification
The hardest cases to reach are the ones where a stop or start lands just after an acknowledged data byte. A repeated start there has to drop the pending write, and a stop there has to start the busy window. A read that follows during that window must be refused. The stimulus reaches these cases with directed sequences: a write cut short by a repeated start, then a read of the same location; a write followed at once by an address probe inside the busy interval; and a write with an extra trailing byte. Seeded random writes and reads over all 512 locations then run against a bench memory model.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

    localparam int EE_WORD_W = 8;
    localparam int EE_AW     = 9;
    localparam int EE_DEPTH  = 1 << EE_AW;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADR,
        ST_WADR_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK,
        ST_HOLD
    } ee_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic scl;
        logic sda;
    } bus_evt_t;

    function automatic logic dev_hit(logic [7:0] b, logic [5:0] hi);
        return b[7:2] == hi;
    endfunction

endpackage

// File: rtl/i2c_ee_bus_sync.sv
module i2c_ee_bus_sync
    import i2c_ee_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);

    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_q, sda_q;
    logic              scl_s, sda_s;

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    always_comb begin
        evt_o.start = scl_s & scl_q & sda_q & ~sda_s;
        evt_o.stop  = scl_s & scl_q & ~sda_q & sda_s;
        evt_o.rise  = ~scl_q & scl_s;
        evt_o.fall  = scl_q & ~scl_s;
        evt_o.scl   = scl_s;
        evt_o.sda   = sda_s;
    end

endmodule

// File: rtl/i2c_ee_store.sv
module i2c_ee_store
    import i2c_ee_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we_i,
    input  logic [EE_AW-1:0]     waddr_i,
    input  logic [EE_WORD_W-1:0] wdata_i,
    input  logic [EE_AW-1:0]     raddr_i,
    output logic [EE_WORD_W-1:0] rdata_o
);

    logic [EE_WORD_W-1:0] mem [EE_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < EE_DEPTH; i++) mem[i] <= '0;
        end else if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[raddr_i];

    // R5: a commit lands in the addressed cell
    p_store_lands_r5: assert property (@(posedge clk) disable iff (rst)
        we_i |=> mem[$past(waddr_i)] == $past(wdata_i));

endmodule

// File: rtl/i2c_ee_ctrl.sv
module i2c_ee_ctrl
    import i2c_ee_pkg::*;
#(
    parameter logic [5:0] DEV_HI      = 6'b101000,
    parameter int         BUSY_CYCLES = 1500
) (
    input  logic                 clk,
    input  logic                 rst,
    input  bus_evt_t             evt_i,
    input  logic [EE_WORD_W-1:0] rdata_i,
    output logic                 we_o,
    output logic [EE_AW-1:0]     waddr_o,
    output logic [EE_WORD_W-1:0] wdata_o,
    output logic [EE_AW-1:0]     raddr_o,
    output logic                 pull_o
);

    localparam int BW = $clog2(BUSY_CYCLES + 1);

    ee_state_e            state;
    logic [3:0]           bitcnt;
    logic [7:0]           rx_sh;
    logic [7:0]           tx_sh;
    logic [EE_AW-1:0]     ptr;
    logic                 rd_mode;
    logic                 pend_v;
    logic [EE_AW-1:0]     pend_addr;
    logic [EE_WORD_W-1:0] pend_data;
    logic [BW-1:0]        busy_cnt;
    logic                 oe;

    assign we_o    = evt_i.stop & pend_v;
    assign waddr_o = pend_addr;
    assign wdata_o = pend_data;
    assign raddr_o = ptr;
    assign pull_o  = oe;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            ptr       <= '0;
            rd_mode   <= 1'b0;
            pend_v    <= 1'b0;
            pend_addr <= '0;
            pend_data <= '0;
            busy_cnt  <= '0;
            oe        <= 1'b0;
        end else begin
            if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;

            if (evt_i.stop) begin
                state <= ST_IDLE;
                oe    <= 1'b0;
                if (pend_v) begin
                    pend_v   <= 1'b0;
                    busy_cnt <= BW'(BUSY_CYCLES);
                end
            end else if (evt_i.start) begin
                state  <= ST_DEV;
                bitcnt <= '0;
                oe     <= 1'b0;
                pend_v <= 1'b0;
            end else begin
                unique case (state)
                    ST_DEV, ST_WADR, ST_WDAT: begin
                        if (evt_i.rise) begin
                            rx_sh  <= {rx_sh[6:0], evt_i.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (evt_i.fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            if (state == ST_DEV) begin
                                if (dev_hit(rx_sh, DEV_HI) && busy_cnt == '0) begin
                                    oe          <= 1'b1;
                                    ptr[EE_AW-1] <= rx_sh[1];
                                    rd_mode     <= rx_sh[0];
                                    state       <= ST_DEV_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_WADR) begin
                                oe         <= 1'b1;
                                ptr[7:0]   <= rx_sh;
                                state      <= ST_WADR_ACK;
                            end else begin
                                oe        <= 1'b1;
                                pend_v    <= 1'b1;
                                pend_addr <= ptr;
                                pend_data <= rx_sh;
                                state     <= ST_WDAT_ACK;
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (evt_i.fall) begin
                            if (rd_mode) begin
                                oe     <= ~rdata_i[7];
                                tx_sh  <= {rdata_i[6:0], 1'b0};
                                bitcnt <= 4'd1;
                                state  <= ST_RDAT;
                            end else begin
                                oe     <= 1'b0;
                                bitcnt <= '0;
                                state  <= ST_WADR;
                            end
                        end
                    end
                    ST_WADR_ACK: begin
                        if (evt_i.fall) begin
                            oe     <= 1'b0;
                            bitcnt <= '0;
                            state  <= ST_WDAT;
                        end
                    end
                    ST_WDAT_ACK: begin
                        if (evt_i.fall) begin
                            oe    <= 1'b0;
                            state <= ST_HOLD;
                        end
                    end
                    ST_RDAT: begin
                        if (evt_i.fall) begin
                            if (bitcnt == 4'd8) begin
                                oe    <= 1'b0;
                                state <= ST_RACK;
                            end else begin
                                oe     <= ~tx_sh[7];
                                tx_sh  <= {tx_sh[6:0], 1'b0};
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (evt_i.fall) state <= ST_HOLD;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R9: the pull enable moves only while the synchronised clock is low
    p_pull_scl_low_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(oe) |-> !evt_i.scl);

    // R8: no address acknowledge inside the busy window
    p_no_ack_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DEV_ACK) |-> busy_cnt == '0);

    // R8: a commit loads the full busy interval
    p_busy_after_commit_r8: assert property (@(posedge clk) disable iff (rst)
        we_o |=> busy_cnt == BW'(BUSY_CYCLES));

    // R2: a start always restarts address reception
    p_start_restarts_r2: assert property (@(posedge clk) disable iff (rst)
        evt_i.start |=> (state == ST_DEV && bitcnt == 4'd0 && !oe));

    // R10: bytes after the data byte are never acknowledged
    p_hold_silent_r10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD) |-> !oe);

endmodule

// File: rtl/i2c_ee_target.sv
module i2c_ee_target
    import i2c_ee_pkg::*;
#(
    parameter logic [5:0] DEV_HI      = 6'b101000,
    parameter int         BUSY_CYCLES = 1500,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o
);

    bus_evt_t             evt;
    logic                 we;
    logic [EE_AW-1:0]     waddr, raddr;
    logic [EE_WORD_W-1:0] wdata, rdata;

    i2c_ee_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt)
    );

    i2c_ee_ctrl #(.DEV_HI(DEV_HI), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .evt_i   (evt),
        .rdata_i (rdata),
        .we_o    (we),
        .waddr_o (waddr),
        .wdata_o (wdata),
        .raddr_o (raddr),
        .pull_o  (sda_pull_o)
    );

    i2c_ee_store u_store (
        .clk     (clk),
        .rst     (rst),
        .we_i    (we),
        .waddr_i (waddr),
        .wdata_i (wdata),
        .raddr_i (raddr),
        .rdata_o (rdata)
    );

endmodule

// File: tb/i2c_ee_target_test.sv
module i2c_ee_target_test;

    localparam int Q    = 10;
    localparam int BUSY = 600;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic pull;
    logic sda_line;

    assign sda_line = sda_m & ~pull;

    always #2 clk = ~clk;

    i2c_ee_target #(.BUSY_CYCLES(BUSY)) uut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_pull_o (pull)
    );

    int n_run = 0, n_fail = 0;
    int pull_viol = 0, hold_viol = 0;
    logic [7:0] model [512];
    bit done = 1'b0;
    logic prev_pull = 1'b0;

    task automatic check(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] devb(logic [8:0] a, bit rd);
        return {6'b101000, a[8], rd};
    endfunction

    // R9 monitor: pull enable may move only while SCL is low
    always @(negedge clk) begin
        if (!rst && pull != prev_pull && scl) pull_viol++;
        prev_pull <= pull;
    end

    task automatic hq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hq(); scl = 1'b1; hq(); sda_m = 1'b0; hq(); scl = 1'b0; hq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hq(); scl = 1'b1; hq(); sda_m = 1'b1; hq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hq(); scl = 1'b1; hq(); scl = 1'b0;
        end
        sda_m = 1'b1; hq(); scl = 1'b1;
        repeat (Q / 2) @(negedge clk);
        ack = (sda_line == 1'b0);
        repeat (Q / 2) @(negedge clk);
        scl = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit m_ack);
        logic first;
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; hq(); scl = 1'b1;
            first = sda_line;
            repeat (Q / 2) @(negedge clk);
            b[i] = sda_line;
            repeat (Q / 2) @(negedge clk);
            if (sda_line != first) hold_viol++;
            scl = 1'b0;
        end
        sda_m = ~m_ack; hq(); scl = 1'b1; hq(); scl = 1'b0;
    endtask

    task automatic ee_write(input logic [8:0] a, input logic [7:0] d, output bit ok);
        bit k1, k2, k3;
        bus_start();
        send_byte(devb(a, 1'b0), k1);
        send_byte(a[7:0], k2);
        send_byte(d, k3);
        bus_stop();
        ok = k1 & k2 & k3;
        if (ok) model[a] = d;
    endtask

    task automatic ee_read(input logic [8:0] a, input bit m_ack, output logic [7:0] d, output bit ok);
        bit k1, k2, k3;
        bus_start();
        send_byte(devb(a, 1'b0), k1);
        send_byte(a[7:0], k2);
        bus_start();
        send_byte(devb(a, 1'b1), k3);
        recv_byte(d, m_ack);
        bus_stop();
        ok = k1 & k2 & k3;
    endtask

    task automatic wait_busy();
        repeat (BUSY + 20) @(negedge clk);
    endtask

    initial begin
        int unsigned sd;
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
        sd = 0;
    end

    initial begin
        logic [7:0] d;
        bit ok, a1, a2, a3;
        int unsigned sd;
        sd = $urandom(32'd4242);
        for (int i = 0; i < 512; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R1: reset state
        check(pull == 1'b0, "R1 pull after reset", int'(pull), 0);
        ee_read(9'h055, 1'b0, d, ok);
        check(ok, "R2 address acknowledged", int'(ok), 1);
        check(d == 8'h00, "R1 memory cleared", d, 0);

        // R4 R5 R6: basic write then read
        ee_write(9'h0A5, 8'h3C, ok);
        check(ok, "R4 write bytes acknowledged", int'(ok), 1);
        wait_busy();
        ee_write(9'h1A5, 8'hC3, ok);
        check(ok, "R7 block one write acknowledged", int'(ok), 1);
        wait_busy();
        ee_read(9'h0A5, 1'b0, d, ok);
        check(ok && d == 8'h3C, "R6 read back block zero", d, 8'h3C);
        ee_read(9'h1A5, 1'b0, d, ok);
        check(ok && d == 8'hC3, "R7 read back block one", d, 8'hC3);

        // R8: busy window refuses the address
        ee_write(9'h042, 8'h5A, ok);
        bus_start();
        send_byte(devb(9'h042, 1'b0), a1);
        bus_stop();
        check(!a1, "R8 address refused while busy", int'(a1), 0);
        wait_busy();
        bus_start();
        send_byte(devb(9'h042, 1'b0), a1);
        bus_stop();
        check(a1, "R8 address accepted after busy", int'(a1), 1);
        ee_read(9'h042, 1'b0, d, ok);
        check(ok && d == 8'h5A, "R5 committed after stop", d, 8'h5A);

        // R3: foreign address ignored until next start
        bus_start();
        send_byte(8'hB0, a1);
        send_byte(8'h10, a2);
        send_byte(8'h77, a3);
        bus_stop();
        check(!a1, "R3 foreign address not acknowledged", int'(a1), 0);
        check(!a2 && !a3, "R3 later bytes not acknowledged", int'(a2 | a3), 0);
        ee_read(9'h010, 1'b0, d, ok);
        check(ok && d == model[9'h010], "R3 memory untouched", d, model[9'h010]);

        // R5: repeated start in place of stop discards the write
        bus_start();
        send_byte(devb(9'h020, 1'b0), a1);
        send_byte(8'h20, a2);
        send_byte(8'h99, a3);
        check(a3, "R5 data byte acknowledged", int'(a3), 1);
        bus_start();
        send_byte(8'hB0, a1);
        bus_stop();
        ee_read(9'h020, 1'b0, d, ok);
        check(ok && d == model[9'h020], "R5 aborted write discarded", d, model[9'h020]);

        // R10: trailing byte in a write
        bus_start();
        send_byte(devb(9'h030, 1'b0), a1);
        send_byte(8'h30, a2);
        send_byte(8'h11, a3);
        send_byte(8'h22, ok);
        bus_stop();
        check(!ok, "R10 extra byte not acknowledged", int'(ok), 0);
        model[9'h030] = 8'h11;
        wait_busy();
        ee_read(9'h030, 1'b0, d, ok);
        check(ok && d == 8'h11, "R10 first data byte stored", d, 8'h11);
        ee_read(9'h031, 1'b0, d, ok);
        check(ok && d == model[9'h031], "R10 next cell untouched", d, model[9'h031]);

        // R6: master acknowledge after read has no effect
        ee_read(9'h1A5, 1'b1, d, ok);
        check(ok && d == 8'hC3, "R6 read with master ack", d, 8'hC3);
        ee_read(9'h0A5, 1'b0, d, ok);
        check(ok && d == 8'h3C, "R6 following read", d, 8'h3C);

        // R4 R6 R7: seeded random traffic
        for (int n = 0; n < 24; n++) begin
            logic [8:0] wa, ra;
            logic [7:0] wd;
            wa = 9'($urandom % 512);
            wd = 8'($urandom);
            ee_write(wa, wd, ok);
            check(ok, "R4 random write acknowledged", int'(ok), 1);
            wait_busy();
            ra = (n % 2 == 0) ? wa : 9'($urandom % 512);
            ee_read(ra, 1'b0, d, ok);
            check(ok && d == model[ra], "R6 random read", d, model[ra]);
        end

        check(pull_viol == 0, "R9 pull changed while SCL high", pull_viol, 0);
        check(hold_viol == 0, "R6 data moved while SCL high", hold_viol, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule